// File: doc/BRIEF.md
# Ternary-Select Reference Frequency Divider

This block turns a fast reference clock into the reference pulse train for a motor speed servo. It counts clock cycles and emits a single-cycle pulse once every N cycles. N is the product of two factors. A coarse power-of-two factor comes from two three-level selects. A fine factor of 3, 4 or 5 comes from a third three-level select. Each three-level select arrives as a two-bit code that an upstream level sensor has already resolved.

In bypass mode no division is applied. An external reference that already runs at servo frequency passes through a two-flop synchronizer. Each of its rising edges then becomes one output pulse. A select change never shortens the period in progress. The new ratio is taken up at the next terminal count.

Top module: `refdiv_top`

## Requirements
- R1: Each select code maps to a level: 00 is low, 01 is middle, 10 is high. With rank low=0, middle=1, high=2, the coarse factor is 128 * 2^(3*rank(sel_a_i) + rank(sel_b_i)).
- R2: The coarse factor is capped at 16384. With both sel_a_i and sel_b_i high, the coarse factor is 16384, the same as high/middle.
- R3: sel_c_i selects the fine factor: low gives 5, middle gives 4, high gives 3.
- R4: The code 11 on any select has the same effect as the high level (10).
- R5: In divide mode, ref_pulse_o rises exactly T = coarse * fine clock cycles after the previous pulse. The first pulse after reset is released comes T cycles after release.
- R6: Every pulse on ref_pulse_o lasts exactly one clock cycle.
- R7: A select change made in the middle of a period does not alter that period. The new ratio governs the period that starts at the next terminal count.
- R8: With bypass_i high, a rising edge on ext_ref_i raises ref_pulse_o for one cycle, in the third clock cycle after the edge is first sampled. A level held high produces no further pulses.
- R9: When bypass_i falls, the divider restarts from zero. The first pulse comes T cycles later.
- R10: While rst is high, ref_pulse_o is low and the divider count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_i | input | 2 | Coarse select, major digit (00 low, 01 middle, 10/11 high) |
| sel_b_i | input | 2 | Coarse select, minor digit |
| sel_c_i | input | 2 | Fine factor select |
| bypass_i | input | 1 | High: pass the synchronized external reference through |
| ext_ref_i | input | 1 | External reference at servo frequency, asynchronous |
| ref_pulse_o | output | 1 | One-cycle servo reference pulse |

## Verification
The checker watches every cycle for the following:
- output pulses are one cycle wide;
- the output is quiet after a reset cycle;
- the spacing between divide-mode pulses stays within the smallest and largest legal ratio;
- each bypass pulse follows an external rising edge with the fixed three-cycle synchronizer latency.

The exact period for each select combination is shown only by the scenarios. These cover the saturation of the high/high coarse code, the aliasing of code 11, a select change taking effect one period late, and the restart after bypass. The scoreboard compares each of these against an interval computed from the requirements.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int unsigned DEF_BASE_SHIFT = 7;
    localparam int unsigned DEF_TOP_SHIFT  = 14;

    typedef enum logic [1:0] {
        LVL_LO     = 2'b00,
        LVL_MID    = 2'b01,
        LVL_HI     = 2'b10,
        LVL_HI_ALT = 2'b11
    } lvl_e;

    typedef struct packed {
        logic [4:0] shift;
        logic [2:0] mult;
    } ratio_t;

    function automatic int unsigned lvl_rank(input logic [1:0] code);
        case (lvl_e'(code))
            LVL_LO:  return 0;
            LVL_MID: return 1;
            default: return 2;
        endcase
    endfunction

    function automatic logic [4:0] coarse_shift(input logic [1:0] major,
                                                input logic [1:0] minor,
                                                input int unsigned base,
                                                input int unsigned top);
        int unsigned step;
        step = 3 * lvl_rank(major) + lvl_rank(minor);
        if (base + step > top) return 5'(top);
        return 5'(base + step);
    endfunction

    function automatic logic [2:0] fine_mult(input logic [1:0] code);
        case (lvl_rank(code))
            0:       return 3'd5;
            1:       return 3'd4;
            default: return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/refdiv_ratio.sv
module refdiv_ratio
    import refdiv_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = DEF_BASE_SHIFT,
    parameter int unsigned TOP_SHIFT  = DEF_TOP_SHIFT,
    parameter int unsigned CNT_W      = TOP_SHIFT + 3
) (
    input  logic [1:0]       sel_a,
    input  logic [1:0]       sel_b,
    input  logic [1:0]       sel_c,
    output logic [CNT_W-1:0] term
);
    ratio_t               ratio;
    logic   [CNT_W-1:0]   total;

    always_comb begin
        ratio.shift = coarse_shift(sel_a, sel_b, BASE_SHIFT, TOP_SHIFT);
        ratio.mult  = fine_mult(sel_c);
        total       = CNT_W'(ratio.mult) << ratio.shift;
        term        = total - CNT_W'(1);
    end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
    parameter int unsigned CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [CNT_W-1:0] term_next,
    output logic             tc
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_q;
    logic             at_end;

    assign at_end = (cnt_q == term_q);
    assign tc     = at_end && !hold;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q  <= '0;
            term_q <= term_next;
        end else if (at_end) begin
            cnt_q  <= '0;
            term_q <= term_next;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/refdiv_edge.sv
module refdiv_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[SYNC_STAGES-1];
    end

    assign rise = chain_q[SYNC_STAGES-1] && !last_q;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
#(
    parameter int unsigned BASE_SHIFT  = DEF_BASE_SHIFT,
    parameter int unsigned TOP_SHIFT   = DEF_TOP_SHIFT,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_a_i,
    input  logic [1:0] sel_b_i,
    input  logic [1:0] sel_c_i,
    input  logic       bypass_i,
    input  logic       ext_ref_i,
    output logic       ref_pulse_o
);
    localparam int unsigned CNT_W = TOP_SHIFT + 3;

    logic [CNT_W-1:0] term_next;
    logic             div_tc;
    logic             ext_rise;
    logic             pulse_q;

    refdiv_ratio #(
        .BASE_SHIFT(BASE_SHIFT),
        .TOP_SHIFT (TOP_SHIFT),
        .CNT_W     (CNT_W)
    ) u_ratio (
        .sel_a(sel_a_i),
        .sel_b(sel_b_i),
        .sel_c(sel_c_i),
        .term (term_next)
    );

    refdiv_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .hold     (bypass_i),
        .term_next(term_next),
        .tc       (div_tc)
    );

    refdiv_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .async_in(ext_ref_i),
        .rise    (ext_rise)
    );

    always_ff @(posedge clk) begin
        if (rst)           pulse_q <= 1'b0;
        else if (bypass_i) pulse_q <= ext_rise;
        else               pulse_q <= div_tc;
    end

    assign ref_pulse_o = pulse_q;
endmodule

// File: rtl/refdiv_checks.sv
module refdiv_checks #(
    parameter int unsigned BASE_SHIFT = 7,
    parameter int unsigned TOP_SHIFT  = 14
) (
    input logic clk,
    input logic rst,
    input logic bypass_i,
    input logic ext_ref_i,
    input logic ref_pulse_o
);
    localparam int unsigned MIN_TOTAL = 3 << BASE_SHIFT;
    localparam int unsigned MAX_TOTAL = 5 << TOP_SHIFT;

    int unsigned ivl_q;
    logic [2:0]  age_q;
    logic        rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || bypass_i) ivl_q <= 0;
        else if (ref_pulse_o) ivl_q <= 1;
        else                  ivl_q <= ivl_q + 1;
        if (rst)                age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            p_reset_quiet_r10: assert (ref_pulse_o == 1'b0)
                else $error("output active after reset cycle");
        end
    end

    p_single_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        ref_pulse_o |=> !ref_pulse_o);

    p_period_floor_r5: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse_o && !$past(bypass_i) && !bypass_i) |-> (ivl_q >= MIN_TOTAL));

    p_period_ceiling_r5: assert property (@(posedge clk) disable iff (rst)
        !bypass_i |-> (ivl_q <= MAX_TOTAL));

    p_bypass_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse_o && $past(bypass_i) && $past(bypass_i, 2) && $past(bypass_i, 3)
         && age_q >= 3'd4) |-> ($past(ext_ref_i, 3) && !$past(ext_ref_i, 4)));
endmodule

bind refdiv_top refdiv_checks #(
    .BASE_SHIFT(BASE_SHIFT),
    .TOP_SHIFT (TOP_SHIFT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bypass_i   (bypass_i),
    .ext_ref_i  (ext_ref_i),
    .ref_pulse_o(ref_pulse_o)
);

// File: tb/tb_refdiv_top.sv
module tb_refdiv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel_a = 2'b00;
    logic [1:0] sel_b = 2'b00;
    logic [1:0] sel_c = 2'b00;
    logic       bypass = 1'b0;
    logic       ext_ref = 1'b0;
    logic       pulse;

    int checks = 0;
    int errors = 0;
    int expq[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    refdiv_top dut (
        .clk        (clk),
        .rst        (rst),
        .sel_a_i    (sel_a),
        .sel_b_i    (sel_b),
        .sel_c_i    (sel_c),
        .bypass_i   (bypass),
        .ext_ref_i  (ext_ref),
        .ref_pulse_o(pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rank(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
    endfunction

    function automatic int period(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
        int e;
        int f;
        e = 7 + 3 * rank(a) + rank(b);
        if (e > 14) e = 14;
        f = 5 - rank(c);
        return f * (1 << e);
    endfunction

    // monitor: pops one expected interval per pulse (R1..R7, R9)
    int  since = 0;
    bit  prev  = 1'b0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst || bypass) begin
                since = 0;
                prev  = 1'b0;
            end else begin
                since++;
                if (pulse) begin
                    check(!prev, "R6 width", 1, 0);
                    if (expq.size() == 0) begin
                        check(1'b0, "R5 unexpected pulse", since, 0);
                    end else begin
                        int e;
                        e = expq.pop_front();
                        check(since == e, "R5/R1/R3 interval", since, e);
                    end
                    since = 0;
                end
                prev = pulse;
            end
        end
    end

    task automatic step(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c, input int n);
        while (expq.size() != 1) @(negedge clk);
        @(negedge clk);
        sel_a = a;
        sel_b = b;
        sel_c = c;
        for (int i = 0; i < n; i++) expq.push_back(period(a, b, c));
    endtask

    task automatic ext_edge_check(input string req);
        ext_ref = 1'b1;
        @(negedge clk);
        check(pulse == 1'b0, req, pulse, 0);
        @(negedge clk);
        check(pulse == 1'b0, req, pulse, 0);
        @(negedge clk);
        check(pulse == 1'b1, req, pulse, 1);
        @(negedge clk);
        check(pulse == 1'b0, req, pulse, 0);
    endtask

    initial begin
        int cyc;
        for (cyc = 0; cyc < 200000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: quiet in reset
        repeat (4) @(negedge clk);
        check(pulse == 1'b0, "R10 reset output", pulse, 0);
        expq.push_back(period(2'b00, 2'b00, 2'b00));
        expq.push_back(period(2'b00, 2'b00, 2'b00));
        rst = 1'b0;

        // R7: change mid-period, old period completes first
        step(2'b00, 2'b00, 2'b01, 2);   // R3 middle -> 512
        step(2'b00, 2'b00, 2'b10, 2);   // R3 high -> 384
        step(2'b00, 2'b00, 2'b11, 1);   // R4 code 11 on fine select
        step(2'b00, 2'b10, 2'b01, 2);   // R1 minor digit high -> 2048
        step(2'b01, 2'b00, 2'b10, 1);   // R1 major digit middle -> 3072
        step(2'b01, 2'b11, 2'b00, 1);   // R4 code 11 on coarse minor -> 20480
        step(2'b10, 2'b01, 2'b10, 1);   // R1 top listed factor -> 49152
        step(2'b10, 2'b10, 2'b10, 1);   // R2 saturation -> 49152

        while (expq.size() != 0) @(negedge clk);
        @(negedge clk);
        bypass = 1'b1;
        sel_a = 2'b00;
        sel_b = 2'b00;
        sel_c = 2'b10;
        repeat (3) @(negedge clk);

        // R8: bypass pulse latency and single pulse per edge
        ext_edge_check("R8 bypass edge");
        begin
            int extra;
            extra = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (pulse) extra++;
            end
            check(extra == 0, "R8 held level", extra, 0);
        end
        ext_ref = 1'b0;
        repeat (4) @(negedge clk);
        ext_edge_check("R8 second edge");
        ext_ref = 1'b0;
        repeat (4) @(negedge clk);

        // R9: restart after bypass
        expq.push_back(period(2'b00, 2'b00, 2'b10));
        expq.push_back(period(2'b00, 2'b00, 2'b10));
        bypass = 1'b0;
        while (expq.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R9 queue drained", expq.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule